// File: doc/BRIEF.md
# Ethernet Pause Frame Flow Controller

This block watches the byte stream that a MAC receiver delivers and picks out MAC control frames that ask the local transmitter to pause. It recognises two kinds. A classic pause frame halts the whole transmitter. A priority flow control (PFC) frame halts only the transmit queues of the priorities it names. For each frame it checks the destination address, the EtherType and the opcode. It then reads the pause time or times carried in the frame and runs a timer for each affected pause output.

The block has no effect unless receive flow control is enabled and the link is in full duplex. Frames sent to the reserved multicast address are always candidates. Frames sent to the station's own unicast address are candidates only when unicast detection is switched on. A frame acts only once it has ended and its status marks it good. Pause time is counted in quanta, and a parameter sets how many clock cycles make one quantum.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `tx_pause` and every bit of `prio_pause` are low.
- R2: Take a good frame addressed to 01-80-C2-00-00-01. Its bytes 12..13 are 0x8808, its bytes 14..15 are the opcode 0x0001, it carries a big-endian pause time T in bytes 16..17, and it is at least 18 bytes long. Such a frame raises `tx_pause` in the cycle after its last byte. `tx_pause` stays high for exactly T*QUANTUM_CYCLES cycles.
- R3: Pause and PFC frames have no effect while `rx_fc_en` is low or `full_duplex` is low.
- R4: When `unicast_det_en` is high, a frame addressed to `station_addr` also qualifies. `station_addr[47:40]` is the first byte on the wire, and `station_addr[40]` must be 0. When `unicast_det_en` is low, such a frame is ignored.
- R5: A frame with any other destination address is ignored, whether that address is multicast or unicast.
- R6: When `pfc_en` is high, a PFC frame raises `prio_pause[k]`. Such a frame has opcode 0x0101, a class vector in bytes 16..17 (bit k of byte 17 enables priority k) and big-endian times for priorities 0..7 in bytes 18..33, and it is at least 34 bytes long. The frame raises `prio_pause[k]` for its own time, and only for priorities whose class bit is set. Other priorities and `tx_pause` keep running unchanged. A PFC frame is ignored while `pfc_en` is low.
- R7: A frame whose EtherType is not 0x8808, or whose opcode is neither 0x0001 nor 0x0101, is ignored.
- R8: A frame whose `rx_good` is low on its last byte is ignored.
- R9: A new qualifying frame reloads the running timer with its time. A time of zero drops the matching pause output in the next cycle.
- R10: If `rx_fc_en` or `full_duplex` goes low, every pause output is low from the next cycle on. The timers are cleared.
- R11: A pause frame shorter than 18 bytes is ignored. A PFC frame shorter than 34 bytes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_good | input | 1 | Frame status, sampled with the last byte |
| station_addr | input | 48 | Station unicast address, first wire byte in bits 47:40 |
| rx_fc_en | input | 1 | Receive flow control enable |
| unicast_det_en | input | 1 | Also accept pause frames sent to the station address |
| pfc_en | input | 1 | Priority flow control mode |
| full_duplex | input | 1 | Link is in full duplex |
| tx_pause | output | 1 | Hold the whole transmitter |
| prio_pause | output | 8 | Hold transmit queue of priority k (bit k) |

## Verification
Suppose a frame qualifies when it should not, or the header capture latches a wrong byte. The pause outputs then show it in the cycle right after that frame's last byte: an output rises when it should stay low, or rises with the wrong length. A fault in a timer's quantum or cycle counter shows up later. It appears as a release one or more cycles early or late, at the end of the pause window, so the outputs are compared against a cycle-exact model on every cycle. A fault in the clearing path shows up one cycle after the enable or the duplex input falls.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NPRIO      = 8;
  localparam int HDR_FIRST  = 12;
  localparam int HDR_LAST   = 33;
  localparam int HDR_BYTES  = HDR_LAST - HDR_FIRST + 1;
  localparam int MIN_PAUSE  = 18;
  localparam int MIN_PFC    = 34;
  localparam logic [15:0] CTL_ETYPE = 16'h8808;
  localparam logic [15:0] OP_PAUSE  = 16'h0001;
  localparam logic [15:0] OP_PFC    = 16'h0101;

  function automatic logic [7:0] resv_mc_byte(input int idx);
    case (idx)
      0:       return 8'h01;
      1:       return 8'h80;
      2:       return 8'hC2;
      5:       return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] addr_byte(input logic [47:0] addr, input int idx);
    return addr[8*(5-idx) +: 8];
  endfunction

  // big-endian 16-bit word at frame offset off, from the captured header bytes
  function automatic logic [15:0] hdr_word(input logic [8*HDR_BYTES-1:0] hdr, input int off);
    return {hdr[8*(off-HDR_FIRST) +: 8], hdr[8*(off-HDR_FIRST+1) +: 8]};
  endfunction

  function automatic int pfc_time_off(input int prio);
    return 18 + 2*prio;
  endfunction
endpackage

// File: rtl/pf_rx_parser.sv
module pf_rx_parser
  import pfc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  input  logic [7:0]               rx_data,
  input  logic                     rx_sof,
  input  logic                     rx_eof,
  input  logic                     rx_good,
  input  logic [47:0]              station_addr,
  output logic                     frame_done,
  output logic                     frame_good,
  output logic                     mc_hit,
  output logic                     uc_hit,
  output logic [5:0]               frame_len,
  output logic [8*HDR_BYTES-1:0]   hdr
);
  logic [5:0] pos;
  logic [4:0] hidx;
  logic       in_da, in_hdr;

  assign pos    = rx_sof ? 6'd0 : frame_len;
  assign in_da  = (pos < 6'd6);
  assign in_hdr = (pos >= 6'(HDR_FIRST)) && (pos <= 6'(HDR_LAST));
  assign hidx   = 5'(pos - 6'(HDR_FIRST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      frame_good <= 1'b0;
      mc_hit     <= 1'b0;
      uc_hit     <= 1'b0;
      frame_len  <= '0;
      hdr        <= '0;
    end else begin
      frame_done <= rx_valid & rx_eof;
      if (rx_valid) begin
        frame_good <= rx_good;
        frame_len  <= (pos == 6'd63) ? pos : pos + 6'd1;
        if (in_da) begin
          mc_hit <= (rx_sof | mc_hit) & (rx_data == resv_mc_byte(int'(pos)));
          uc_hit <= (rx_sof | uc_hit) & (rx_data == addr_byte(station_addr, int'(pos)))
                    & ~station_addr[40];
        end
        if (in_hdr) hdr[8*hidx +: 8] <= rx_data;
      end
    end
  end

  // R11: length grows by one per byte within a frame until saturation
  a_r11_len_step: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_sof && frame_len < 6'd63 |=> frame_len == $past(frame_len) + 6'd1);
  // R8: a completion pulse follows exactly a sampled last byte
  a_r8_done_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(rx_valid && rx_eof));
endmodule

// File: rtl/pf_quanta_timer.sv
module pf_quanta_timer #(
  parameter int QUANTUM_CYCLES = 64,
  parameter int TIME_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic              paused
);
  localparam int CW = (QUANTUM_CYCLES > 1) ? $clog2(QUANTUM_CYCLES) : 1;
  localparam logic [CW-1:0] CMAX = CW'(QUANTUM_CYCLES - 1);

  logic [TIME_W-1:0] quanta;
  logic [CW-1:0]     cyc;
  logic              quantum_end;

  assign quantum_end = (quanta != '0) && (cyc == CMAX);
  assign paused      = (quanta != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      quanta <= '0;
      cyc    <= '0;
    end else if (load) begin
      quanta <= load_val;
      cyc    <= '0;
    end else if (quantum_end) begin
      quanta <= quanta - 1'b1;
      cyc    <= '0;
    end else if (quanta != '0) begin
      cyc    <= cyc + 1'b1;
    end
  end

  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !paused);
  a_r9_zero_releases: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr && load_val == '0 |=> !paused);
  a_r2_holds_mid_quantum: assert property (@(posedge clk) disable iff (!rst_n)
    paused && !clr && !load && !quantum_end |=> paused);
  a_r9_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> quanta == $past(load_val));
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int QUANTUM_CYCLES = 64,
  parameter int TIME_W         = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_good,
  input  logic [47:0] station_addr,
  input  logic        rx_fc_en,
  input  logic        unicast_det_en,
  input  logic        pfc_en,
  input  logic        full_duplex,
  output logic        tx_pause,
  output logic [7:0]  prio_pause
);
  logic                   frame_done, frame_good, mc_hit, uc_hit;
  logic [5:0]             frame_len;
  logic [8*HDR_BYTES-1:0] hdr;

  pf_rx_parser u_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
    .station_addr(station_addr), .frame_done(frame_done), .frame_good(frame_good),
    .mc_hit(mc_hit), .uc_hit(uc_hit), .frame_len(frame_len), .hdr(hdr)
  );

  // named decode events
  logic              fc_active, addr_ok, ctl_frame, pause_cmd, pfc_cmd;
  logic [15:0]       etype, opcode, word16;
  logic [NPRIO-1:0]  pfc_load;

  assign fc_active = rx_fc_en & full_duplex;
  assign addr_ok   = mc_hit | (unicast_det_en & uc_hit);
  assign etype     = hdr_word(hdr, 12);
  assign opcode    = hdr_word(hdr, 14);
  assign word16    = hdr_word(hdr, 16);
  assign ctl_frame = frame_done & frame_good & fc_active & addr_ok & (etype == CTL_ETYPE);
  assign pause_cmd = ctl_frame & (opcode == OP_PAUSE) & (frame_len >= 6'(MIN_PAUSE));
  assign pfc_cmd   = ctl_frame & pfc_en & (opcode == OP_PFC) & (frame_len >= 6'(MIN_PFC));

  pf_quanta_timer #(.QUANTUM_CYCLES(QUANTUM_CYCLES), .TIME_W(TIME_W)) u_global (
    .clk(clk), .rst_n(rst_n), .clr(!fc_active), .load(pause_cmd),
    .load_val(TIME_W'(word16)), .paused(tx_pause)
  );

  for (genvar k = 0; k < NPRIO; k++) begin : g_prio
    assign pfc_load[k] = pfc_cmd & word16[k];
    pf_quanta_timer #(.QUANTUM_CYCLES(QUANTUM_CYCLES), .TIME_W(TIME_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!fc_active), .load(pfc_load[k]),
      .load_val(TIME_W'(hdr_word(hdr, pfc_time_off(k)))), .paused(prio_pause[k])
    );
    a_r6_rise_needs_pfc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prio_pause[k]) |-> $past(pfc_load[k]));
  end

  a_r2_rise_needs_pause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(pause_cmd));
  a_r10_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_active |=> !tx_pause && prio_pause == '0);
  a_r6_pfc_leaves_global: assert property (@(posedge clk) disable iff (!rst_n)
    pfc_cmd && fc_active && !tx_pause |=> !tx_pause);
  a_r8_bad_frame_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_good && !tx_pause |=> !tx_pause);
endmodule

// File: tb/tb_pause_flow_ctrl.sv
module tb_pause_flow_ctrl;
  localparam int Q = 8;
  localparam logic [47:0] RESV_MC = 48'h0180C2000001;
  localparam logic [47:0] STATION = 48'h02A1B2C3D4E5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic [7:0] rx_data = 0;
  logic [47:0] station_addr = STATION;
  logic rx_fc_en = 1, unicast_det_en = 0, pfc_en = 1, full_duplex = 1;
  logic tx_pause;
  logic [7:0] prio_pause;

  always #10 clk = ~clk;

  pause_flow_ctrl #(.QUANTUM_CYCLES(Q)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good), .station_addr(station_addr),
    .rx_fc_en(rx_fc_en), .unicast_det_en(unicast_det_en), .pfc_en(pfc_en),
    .full_duplex(full_duplex), .tx_pause(tx_pause), .prio_pause(prio_pause)
  );

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R1";

  // pending frame seen by the model
  int pend_req = 0, pend_seen = 0;
  logic [47:0] p_da; logic [15:0] p_et, p_op, p_w; logic [127:0] p_tim;
  logic p_good; int p_len;

  int rem_g;
  int rem_p [8];

  function automatic bit fr_ctl(input logic [47:0] da, input logic [15:0] et,
                                input bit good, input bit en, input bit fd, input bit uce);
    bit addr = (da == RESV_MC) || (uce && da == station_addr && !station_addr[40]);
    return good && en && fd && addr && et == 16'h8808;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n || !rx_fc_en || !full_duplex) begin
      rem_g <= 0;
      for (int k = 0; k < 8; k++) rem_p[k] <= 0;
      if (pend_req != pend_seen) pend_seen <= pend_req;
    end else begin
      bit ctl, cp, cf;
      ctl = (pend_req != pend_seen) && fr_ctl(p_da, p_et, p_good, rx_fc_en, full_duplex, unicast_det_en);
      cp = ctl && p_op == 16'h0001 && p_len >= 18;
      cf = ctl && pfc_en && p_op == 16'h0101 && p_len >= 34;
      pend_seen <= pend_req;
      if (cp) rem_g <= int'(p_w) * Q;
      else if (rem_g > 0) rem_g <= rem_g - 1;
      for (int k = 0; k < 8; k++) begin
        if (cf && p_w[k]) rem_p[k] <= int'(p_tim[16*k +: 16]) * Q;
        else if (rem_p[k] > 0) rem_p[k] <= rem_p[k] - 1;
      end
    end
  end

  always @(negedge clk) begin
    logic [7:0] ep;
    for (int k = 0; k < 8; k++) ep[k] = (rem_p[k] > 0);
    checks++;
    if (tx_pause !== (rem_g > 0) || prio_pause !== ep) begin
      fails++;
      $display("FAIL %s: tx_pause=%0b prio_pause=%02h expected tx_pause=%0b prio_pause=%02h",
               cur_tag, tx_pause, prio_pause, rem_g > 0, ep);
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles == 190000) begin
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [47:0] da, input logic [15:0] et, input logic [15:0] op,
                      input logic [15:0] w, input logic [127:0] tim, input bit good, input int len);
    logic [7:0] fb [64];
    for (int i = 0; i < 64; i++) fb[i] = 8'h00;
    for (int i = 0; i < 6; i++) begin fb[i] = da[8*(5-i) +: 8]; fb[6+i] = 8'h10 + 8'(i); end
    fb[12] = et[15:8]; fb[13] = et[7:0];
    fb[14] = op[15:8]; fb[15] = op[7:0];
    fb[16] = w[15:8];  fb[17] = w[7:0];
    for (int k = 0; k < 8; k++) begin
      fb[18+2*k] = tim[16*k+8 +: 8]; fb[19+2*k] = tim[16*k +: 8];
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fb[i]; rx_sof = (i == 0); rx_eof = (i == len-1); rx_good = good;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0;
    p_da = da; p_et = et; p_op = op; p_w = w; p_tim = tim; p_good = good; p_len = len;
    pend_req++;
  endtask

  task automatic set_ctl(input bit en, input bit fd, input bit uce, input bit pe);
    rx_fc_en = en; full_duplex = fd; unicast_det_en = uce; pfc_en = pe;
  endtask

  logic [127:0] tset;

  initial begin
    for (int k = 0; k < 8; k++) tset[16*k +: 16] = 16'(k + 1);
    cur_tag = "R1"; idle(5); rst_n = 1; idle(3);

    cur_tag = "R2"; set_ctl(1, 1, 0, 1);
    send(RESV_MC, 16'h8808, 16'h0001, 16'd3, '0, 1, 64); idle(40);
    cur_tag = "R9";
    send(RESV_MC, 16'h8808, 16'h0001, 16'd6, '0, 1, 64); idle(10);
    send(RESV_MC, 16'h8808, 16'h0001, 16'd2, '0, 1, 64); idle(5);
    send(RESV_MC, 16'h8808, 16'h0001, 16'd0, '0, 1, 64); idle(10);
    cur_tag = "R3"; set_ctl(0, 1, 0, 1);
    send(RESV_MC, 16'h8808, 16'h0001, 16'd3, '0, 1, 64); idle(5);
    set_ctl(1, 0, 0, 1);
    send(RESV_MC, 16'h8808, 16'h0101, 16'h00FF, tset, 1, 64); idle(5);
    cur_tag = "R4"; set_ctl(1, 1, 0, 1);
    send(STATION, 16'h8808, 16'h0001, 16'd2, '0, 1, 64); idle(5);
    set_ctl(1, 1, 1, 1);
    send(STATION, 16'h8808, 16'h0001, 16'd2, '0, 1, 64); idle(25);
    cur_tag = "R5";
    send(48'h0180C2000002, 16'h8808, 16'h0001, 16'd2, '0, 1, 64); idle(5);
    send(48'h02A1B2C3D4E6, 16'h8808, 16'h0001, 16'd2, '0, 1, 64); idle(5);
    cur_tag = "R6";
    send(RESV_MC, 16'h8808, 16'h0101, 16'h00A5, tset, 1, 64); idle(80);
    set_ctl(1, 1, 0, 0);
    send(RESV_MC, 16'h8808, 16'h0101, 16'h00FF, tset, 1, 64); idle(5);
    cur_tag = "R7"; set_ctl(1, 1, 0, 1);
    send(RESV_MC, 16'h8809, 16'h0001, 16'd2, '0, 1, 64); idle(3);
    send(RESV_MC, 16'h8808, 16'h0002, 16'd2, '0, 1, 64); idle(3);
    cur_tag = "R8";
    send(RESV_MC, 16'h8808, 16'h0001, 16'd2, '0, 0, 64); idle(3);
    cur_tag = "R11";
    send(RESV_MC, 16'h8808, 16'h0001, 16'd2, '0, 1, 17); idle(3);
    send(RESV_MC, 16'h8808, 16'h0001, 16'd1, '0, 1, 18); idle(12);
    send(RESV_MC, 16'h8808, 16'h0101, 16'h00FF, tset, 1, 33); idle(3);
    cur_tag = "R10";
    send(RESV_MC, 16'h8808, 16'h0101, 16'h00FF, tset, 1, 64); idle(4);
    send(RESV_MC, 16'h8808, 16'h0001, 16'd5, '0, 1, 64); idle(6);
    full_duplex = 0; idle(4); full_duplex = 1; idle(4);

    cur_tag = "R2-mix";
    void'($urandom(32'd1234));
    for (int n = 0; n < 300; n++) begin
      logic [47:0] da; logic [15:0] et, op, w; logic [127:0] tm;
      int len; bit g;
      case ($urandom % 4)
        0, 1: da = RESV_MC;
        2:    da = STATION;
        default: da = ($urandom % 2) ? 48'h0180C2000003 : 48'h02A1B2C3D4E7;
      endcase
      et = ($urandom % 8 == 0) ? 16'h88A8 : 16'h8808;
      case ($urandom % 5)
        0, 1: op = 16'h0001;
        2, 3: op = 16'h0101;
        default: op = 16'h0003;
      endcase
      for (int k = 0; k < 8; k++) tm[16*k +: 16] = 16'($urandom % 7);
      w = (op == 16'h0001) ? 16'($urandom % 7) : 16'($urandom % 256);
      len = ($urandom % 6 == 0) ? 20 + int'($urandom % 14) : 64;
      g = ($urandom % 8 != 0);
      set_ctl($urandom % 8 != 0, $urandom % 8 != 0, $urandom % 2, $urandom % 4 != 0);
      send(da, et, op, w, tm, g, len);
      idle(int'($urandom % 30));
    end
    idle(100);
    finish_run();
  end
endmodule